// File: doc/BRIEF.md
# Dynamic Interleaved Thread Scheduler

This block picks, on every clock, which of the hardware threads of a multithreaded in-order core may dispatch its next packet into the shared execute pipeline. A rotation pointer names the owner of each cycle's slot and steps to the next thread on every clock. The number of threads equals the pipeline depth, so under strict rotation a thread's packet has left the pipeline before that thread's next slot comes round, and software never sees an execution latency.

In the dynamic mode a slot whose owner cannot use it, because the owner is idle or stalled, is handed to another thread. The receiving thread must have a packet flagged simple, meaning it can complete early and cannot conflict with a packet of the same thread still in flight. The per-thread inputs are ready, stall and simple. The output is a one-hot grant, which is all zeros when no thread may issue.

Top module: `thread_issue_sched`

## Requirements
- R1: After reset the rotation pointer starts at thread 0, so with every thread ready the first grant is thread 0, then thread 1, then thread 2.
- R2: With dyn_mode low (strict rotation), only the slot owner can be granted. If the owner cannot issue, the grant is all zeros.
- R3: grant has at most one bit set in every cycle. Bit i of grant means thread i dispatches in that cycle.
- R4: If the slot owner is ready, not stalled, and either flagged simple or without a packet in flight, the owner receives the grant in both modes.
- R5: In dynamic mode (dyn_mode high), when the owner cannot issue, the slot goes to the first thread after the owner, in rotation order, that is ready, not stalled and flagged simple.
- R6: A thread has a packet in flight if it was granted in either of the previous DEPTH-1 cycles (2 at the default depth of 3). Such a thread is never granted a packet whose simple flag is low.
- R7: When no thread qualifies, the grant is all zeros (a bubble).
- R8: The rotation pointer advances by one thread (wrapping 2 to 0) on every clock, whether the slot was used or not.
- R9: A thread whose stall input is high, or whose ready input is low, is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dyn_mode | input | 1 | 0: strict rotation, 1: slot donation to simple packets |
| thr_ready | input | NT | Thread has a packet waiting |
| thr_stall | input | NT | Thread is stalled and may not dispatch |
| thr_simple | input | NT | Thread's waiting packet is flagged simple |
| grant | output | NT | One-hot dispatch grant, zero for a bubble |

## Verification
The embedded properties check on every cycle that the grant is one-hot or empty, that the pointer steps by one, that stalled or idle threads are never granted, that strict mode never grants a non-owner, that a foreign grant always carries a simple packet, and that a non-simple packet never enters behind its own in-flight packet. The bench's scenarios are needed to show the exact choice of recipient: the rotation order from the owner, the owner's priority over donors, the bubbles, and the start-of-rotation position after reset. These are compared cycle by cycle against a behavioural model under directed and pseudo-random input patterns.

// File: rtl/thread_issue_sched_pkg.sv
package thread_issue_sched_pkg;
  typedef enum logic {
    ISSUE_STRICT  = 1'b0,
    ISSUE_DYNAMIC = 1'b1
  } issue_mode_e;
endpackage

// File: rtl/thr_rotor.sv
module thr_rotor #(
  parameter int NT = 3,
  localparam int PW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] ptr,
  output logic [NT-1:0] owner_onehot
);
  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    if (int'(p) >= NT - 1) step_ptr = '0;
    else                   step_ptr = p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= step_ptr(ptr);
  end

  always_comb begin
    owner_onehot = '0;
    owner_onehot[ptr] = 1'b1;
  end

  // R8: the pointer moves one place on every clock
  p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(ptr) == ((int'($past(ptr)) + 1) % NT)));
endmodule

// File: rtl/thr_flight.sv
module thr_flight #(
  parameter int NT    = 3,
  parameter int DEPTH = 3,
  localparam int HW   = (DEPTH > 1) ? DEPTH - 1 : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] grant,
  input  logic [NT-1:0] simple,
  output logic [NT-1:0] inflight
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [HW-1:0] hist;
    always_ff @(posedge clk) begin
      if (!rst_n)        hist <= '0;
      else if (HW == 1)  hist <= grant[t];
      else               hist <= {hist[HW-2:0], grant[t]};
    end
    assign inflight[t] = |hist;

    // R6: a non-simple packet never follows its own packet still in the pipe
    p_nonsimple_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[t] && !simple[t]) |-> (hist == '0));
  end
endmodule

// File: rtl/thr_pick.sv
module thr_pick #(
  parameter int NT = 3,
  localparam int PW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [PW-1:0] ptr,
  input  logic          dyn,
  input  logic [NT-1:0] owner_ok,
  input  logic [NT-1:0] donee_ok,
  output logic [NT-1:0] grant
);
  // first qualifying thread strictly after the owner, in rotation order
  function automatic logic [NT-1:0] next_after(input logic [PW-1:0] p,
                                               input logic [NT-1:0] cand);
    logic [NT-1:0] res;
    logic          found;
    res   = '0;
    found = 1'b0;
    for (int k = 1; k < NT; k++) begin
      int idx;
      idx = (int'(p) + k) % NT;
      if (!found && cand[idx]) begin
        res[idx] = 1'b1;
        found    = 1'b1;
      end
    end
    return res;
  endfunction

  always_comb begin
    grant = '0;
    if (owner_ok[ptr]) grant[ptr] = 1'b1;
    else if (dyn)      grant = next_after(ptr, donee_ok);
  end
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
  import thread_issue_sched_pkg::*;
#(
  parameter int NT    = 3,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dyn_mode,
  input  logic [NT-1:0] thr_ready,
  input  logic [NT-1:0] thr_stall,
  input  logic [NT-1:0] thr_simple,
  output logic [NT-1:0] grant
);
  localparam int PW = (NT > 1) ? $clog2(NT) : 1;

  issue_mode_e   mode;
  logic [PW-1:0] ptr;
  logic [NT-1:0] owner_onehot;
  logic [NT-1:0] inflight;
  logic [NT-1:0] can_go;
  logic [NT-1:0] owner_ok;
  logic [NT-1:0] donee_ok;

  assign mode     = issue_mode_e'(dyn_mode);
  assign can_go   = thr_ready & ~thr_stall;
  assign owner_ok = can_go & (thr_simple | ~inflight);
  assign donee_ok = can_go & thr_simple;

  thr_rotor #(.NT(NT)) u_rotor (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .owner_onehot(owner_onehot)
  );

  thr_flight #(.NT(NT), .DEPTH(DEPTH)) u_flight (
    .clk(clk), .rst_n(rst_n), .grant(grant), .simple(thr_simple),
    .inflight(inflight)
  );

  thr_pick #(.NT(NT)) u_pick (
    .ptr(ptr), .dyn(mode == ISSUE_DYNAMIC), .owner_ok(owner_ok),
    .donee_ok(donee_ok), .grant(grant)
  );

  // R3: never more than one dispatch per cycle
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9: idle or stalled threads are never granted
  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~(thr_ready & ~thr_stall)) == '0);

  // R2: strict rotation grants only the slot owner
  p_strict_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dyn_mode |-> ((grant & ~owner_onehot) == '0));

  // R5: a donated slot always carries a simple packet
  p_foreign_simple_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~owner_onehot) != '0) |-> (dyn_mode && ((grant & ~thr_simple) == '0)));

  // R4: an owner able to issue is never passed over
  p_owner_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner_onehot & owner_ok) != '0) |-> (grant == owner_onehot));
endmodule

// File: tb/thread_issue_sched_test.sv
module thread_issue_sched_test;
  localparam int NT = 3;
  localparam int DEPTH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dyn_mode = 1'b0;
  logic [NT-1:0] thr_ready = '0, thr_stall = '0, thr_simple = '0;
  logic [NT-1:0] grant;

  int total = 0, bad = 0;
  int cyc = 0;
  int last_g[NT];
  logic done = 1'b0;

  always #2 clk = ~clk;

  thread_issue_sched #(.NT(NT), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .dyn_mode(dyn_mode), .thr_ready(thr_ready),
    .thr_stall(thr_stall), .thr_simple(thr_simple), .grant(grant)
  );

  function automatic logic [NT-1:0] model_grant();
    logic [NT-1:0] g;
    int own;
    g = '0;
    own = cyc % NT;
    for (int k = 0; k < NT; k++) begin
      int t;
      bit busy, okay;
      t = (own + k) % NT;
      busy = (cyc - last_g[t]) < DEPTH;
      if (k == 0) okay = thr_ready[t] && !thr_stall[t] && (thr_simple[t] || !busy);
      else        okay = dyn_mode && thr_ready[t] && !thr_stall[t] && thr_simple[t];
      if (okay && g == '0) g[t] = 1'b1;
    end
    return g;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc = 0;
    for (int t = 0; t < NT; t++) last_g[t] = -100;
  endtask

  task automatic step(input logic md, input logic [NT-1:0] rd,
                      input logic [NT-1:0] st, input logic [NT-1:0] sp,
                      input string req);
    logic [NT-1:0] exp;
    dyn_mode = md; thr_ready = rd; thr_stall = st; thr_simple = sp;
    @(negedge clk);
    exp = model_grant();
    total++;
    if (grant !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: grant=%b expected=%b", req, cyc, grant, exp);
    end
    for (int t = 0; t < NT; t++) if (exp[t]) last_g[t] = cyc;
    cyc++;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    // R1: rotation begins at thread 0
    step(1'b0, 3'b111, 3'b000, 3'b000, "R1");
    step(1'b0, 3'b111, 3'b000, 3'b000, "R1");
    step(1'b0, 3'b111, 3'b000, 3'b000, "R1");
    // R2 R8: strict rotation, idle owner gives a bubble, pointer still moves
    for (int i = 0; i < 6; i++) step(1'b0, 3'b101, 3'b000, 3'b111, "R2_R8");
    // R9: stalled thread skipped
    for (int i = 0; i < 6; i++) step(1'b0, 3'b111, 3'b100, 3'b000, "R9");
    // R5: dynamic mode, thread 1 idle, thread 2 simple picks up its slot
    for (int i = 0; i < 6; i++) step(1'b1, 3'b101, 3'b000, 3'b100, "R5");
    // R5: rotation order from owner, both others simple
    for (int i = 0; i < 6; i++) step(1'b1, 3'b110, 3'b000, 3'b110, "R5");
    // R6 R7: lone non-simple thread in dynamic mode waits out its packet
    for (int i = 0; i < 6; i++) step(1'b1, 3'b010, 3'b000, 3'b000, "R6_R7");
    // R5 R6: lone simple thread issues every cycle
    for (int i = 0; i < 6; i++) step(1'b1, 3'b010, 3'b000, 3'b010, "R5_R6");
    // R4: owner keeps its slot against simple donors
    for (int i = 0; i < 6; i++) step(1'b1, 3'b111, 3'b000, 3'b111, "R4");
    // R7: nothing eligible
    for (int i = 0; i < 3; i++) step(1'b1, 3'b111, 3'b111, 3'b111, "R7");
    // R1: mid-run reset restarts at thread 0
    do_reset();
    step(1'b0, 3'b111, 3'b000, 3'b000, "R1");
    step(1'b0, 3'b111, 3'b000, 3'b000, "R1");
    // R3 R4 R5 R6 R9: pseudo-random patterns in both modes
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[9], lfsr[2:0] | lfsr[12:10], lfsr[5:3] & lfsr[8:6], lfsr[8:6],
           "R3_R4_R5_R6_R9");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule